// File: doc/BRIEF.md
# Parallel Bit-Slice Distributed-Arithmetic FIR Filter

This block is an N-tap FIR filter with runtime-reloadable taps. It takes one unsigned sample per clock and delivers one full-precision result per clock. It uses no multipliers. The newest N samples are kept in a shift register, and neighbouring samples are grouped into pairs. Each pair owns a small bank of three registers: the even tap, the odd tap, and their sum. For every bit position of the sample word, a four-way select reads that bank using the two sample bits of that position. All bit positions are served in parallel from the same bank.

For each bit position, a pipelined adder tree sums the pair contributions. A final pipelined tree shifts each bit-position sum by its weight and adds the results to form the output. Signed input data is supported by adding a fixed offset before the block. Coefficients are signed and are written one tap at a time through a simple write port, while the filter keeps streaming.

Top module: `dafir_top`

## Requirements
- R1: After reset, outValid is low, and every tap reads as zero, so any sample stream produces outY = 0.
- R2: When outValid is high, outY equals sum over k of h(k)·x(n−k) for k = 0..N−1. Here x(n) is the newest accepted sample, samples are unsigned, taps are signed two's complement of COEF_W bits, and the result is exact in two's complement.
- R3: outValid rises exactly LAT = 2 + ceil(log2(N/2)) + ceil(log2(SAMPLE_W)) clock edges after the edge that accepts a sample. It is 7 for N = 8 and SAMPLE_W = 8. Every accepted sample yields exactly one valid output.
- R4: A sample is accepted only on an edge where inValid is high. Cycles with inValid low leave the sample history unchanged and produce no output.
- R5: A write on an edge with coefWrEn high sets tap h(coefWrAddr) to coefWrData. Address bit 0 selects the odd tap of a pair, and the upper address bits give the pair index. A write applies to the sample accepted on the same edge and to every later sample. Samples accepted earlier keep the old taps.
- R6: Back-to-back valid samples are accepted on every clock with no stall, and outputs leave in input order.
- R7: Extreme operands produce no overflow. The largest sample with all taps at the most negative value, or at the most positive value, gives the exact product sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Sample strobe |
| inSample | input | SAMPLE_W | Unsigned input sample |
| coefWrEn | input | 1 | Tap write strobe |
| coefWrAddr | input | log2(TAPS) | Tap index to write |
| coefWrData | input | COEF_W | Signed tap value |
| outValid | output | 1 | Result strobe |
| outY | output | COEF_W+1+log2(TAPS/2)+SAMPLE_W | Signed filter result |

## Verification
The bench builds the filter with eight taps, 8-bit samples and 8-bit taps, giving four pairs, two adder stages per bit slice and three shift-add stages. That size lets every sample value from 0 to 255 stream back-to-back through several tap sets, including all-maximum and all-minimum taps. It also lets an impulse reveal each tap's address mapping individually. Further runs interleave idle cycles with valid samples and rewrite taps while data is in flight, so the tap switch point is checked at single-cycle resolution.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // accept a new sample into the history
    logic coefLoad;  // write one tap this cycle
    logic coefOdd;   // the written tap is the odd member of its pair
  } strobe_t;

endpackage

// File: rtl/dafir_ctrl.sv
module dafir_ctrl
  import dafir_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int PSEL_W = 2,
  parameter int LAT    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              coefWrEn,
  input  logic [ADDR_W-1:0] coefWrAddr,
  output strobe_t           strb,
  output logic [PSEL_W-1:0] pairSel,
  output logic              outValid
);

  localparam int CNT_W = $clog2(LAT + 1);

  logic [LAT-1:0] validPipe;
  logic [CNT_W-1:0] sinceRst;

  always_comb begin
    strb.shiftEn  = inValid;
    strb.coefLoad = coefWrEn;
    strb.coefOdd  = coefWrAddr[0];
  end

  assign pairSel = PSEL_W'(coefWrAddr >> 1);

  generate
    if (LAT == 1) begin : gLat1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) validPipe <= '0;
        else       validPipe <= inValid;
    end else begin : gLatN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) validPipe <= '0;
        else       validPipe <= {validPipe[LAT-2:0], inValid};
    end
  endgenerate

  assign outValid = validPipe[LAT-1];

  // cycles elapsed since reset, saturating at LAT
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                   sinceRst <= '0;
    else if (sinceRst != CNT_W'(LAT)) sinceRst <= sinceRst + 1'b1;

  // R3
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (sinceRst == CNT_W'(LAT)));

endmodule

// File: rtl/dafir_ppg.sv
module dafir_ppg #(
  parameter int W = 8,
  parameter int L = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                load,
  input  logic                odd,
  input  logic signed [W-1:0] coefData,
  input  logic [L-1:0]        bitsEven,
  input  logic [L-1:0]        bitsOdd,
  output logic [L-1:0][W:0]   pp
);

  localparam int PW = W + 1;

  logic signed [W-1:0]  hEven;
  logic signed [W-1:0]  hOdd;
  logic signed [PW-1:0] hPair;

  // three-entry register bank shared by all bit slices
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hEven <= '0;
      hOdd  <= '0;
      hPair <= '0;
    end else if (load) begin
      if (odd) begin
        hOdd  <= coefData;
        hPair <= PW'(hEven) + PW'(coefData);
      end else begin
        hEven <= coefData;
        hPair <= PW'(coefData) + PW'(hOdd);
      end
    end
  end

  // one four-way select per bit slice, registered
  for (genvar b = 0; b < L; b++) begin : gSlice
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pp[b] <= '0;
      else begin
        unique case ({bitsOdd[b], bitsEven[b]})
          2'b00: pp[b] <= '0;
          2'b01: pp[b] <= PW'(hEven);
          2'b10: pp[b] <= PW'(hOdd);
          2'b11: pp[b] <= hPair;
        endcase
      end
    end
  end

  // R5
  pair_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    hPair == PW'(hEven) + PW'(hOdd));

  // R5
  coef_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (load && !odd) |=> (hEven == $past(coefData)));

endmodule

// File: rtl/dafir_addtree.sv
module dafir_addtree #(
  parameter int LEAVES = 4,
  parameter int WIDTH  = 11
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [WIDTH-1:0] leaf [LEAVES],
  output logic signed [WIDTH-1:0] sum
);

  localparam int DEPTH  = $clog2(LEAVES);
  localparam int PADDED = 1 << DEPTH;

  for (genvar lv = 0; lv <= DEPTH; lv++) begin : stage
    localparam int CNT = PADDED >> lv;
    logic signed [WIDTH-1:0] node [CNT];

    if (lv == 0) begin : gLeaf
      for (genvar i = 0; i < CNT; i++) begin : gPad
        if (i < LEAVES) begin : gUse
          assign node[i] = leaf[i];
        end else begin : gZero
          assign node[i] = '0;
        end
      end
    end else begin : gAdd
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < CNT; i++) node[i] <= '0;
        end else begin
          for (int i = 0; i < CNT; i++)
            node[i] <= stage[lv-1].node[2*i] + stage[lv-1].node[2*i+1];
        end
      end
    end
  end

  assign sum = stage[DEPTH].node[0];

endmodule

// File: rtl/dafir_datapath.sv
module dafir_datapath
  import dafir_pkg::*;
#(
  parameter int TAPS   = 8,
  parameter int L      = 8,
  parameter int W      = 8,
  parameter int PSEL_W = 2,
  parameter int OW     = 19
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [PSEL_W-1:0]    pairSel,
  input  logic [L-1:0]         sample,
  input  logic signed [W-1:0]  coefData,
  output logic signed [OW-1:0] yOut
);

  localparam int PAIRS = TAPS / 2;
  localparam int PW    = W + 1;
  localparam int CW    = PW + $clog2(PAIRS);

  logic [L-1:0] hist [TAPS];
  logic [L-1:0][PW-1:0] ppBus [PAIRS];
  logic signed [CW-1:0] sliceSum [L];
  logic signed [OW-1:0] weighted [L];

  // sample history, newest at index 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < TAPS; k++) hist[k] <= '0;
    end else if (strb.shiftEn) begin
      hist[0] <= sample;
      for (int k = 1; k < TAPS; k++) hist[k] <= hist[k-1];
    end
  end

  // one partial product generator per sample pair
  for (genvar p = 0; p < PAIRS; p++) begin : gPair
    logic pairLoad;
    assign pairLoad = strb.coefLoad && (pairSel == PSEL_W'(p));

    dafir_ppg #(.W(W), .L(L)) uPpg (
      .clk      (clk),
      .rstN     (rstN),
      .load     (pairLoad),
      .odd      (strb.coefOdd),
      .coefData (coefData),
      .bitsEven (hist[2*p]),
      .bitsOdd  (hist[2*p+1]),
      .pp       (ppBus[p])
    );
  end

  // per bit-slice adder trees across pairs
  for (genvar b = 0; b < L; b++) begin : gSliceTree
    logic signed [CW-1:0] leafB [PAIRS];
    for (genvar p = 0; p < PAIRS; p++) begin : gLeaf
      assign leafB[p] = CW'($signed(ppBus[p][b]));
    end

    dafir_addtree #(.LEAVES(PAIRS), .WIDTH(CW)) uTree (
      .clk  (clk),
      .rstN (rstN),
      .leaf (leafB),
      .sum  (sliceSum[b])
    );

    // bit position b carries weight 2^b
    assign weighted[b] = OW'(sliceSum[b]) <<< b;
  end

  // weighted shift-add tree across slices
  dafir_addtree #(.LEAVES(L), .WIDTH(OW)) uShiftAdd (
    .clk  (clk),
    .rstN (rstN),
    .leaf (weighted),
    .sum  (yOut)
  );

  // R4
  sipo_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> (hist[0] == $past(sample)) && (hist[1] == $past(hist[0])));

  // R4
  sipo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shiftEn |=> $stable(hist[0]) && $stable(hist[TAPS-1]));

endmodule

// File: rtl/dafir_top.sv
module dafir_top
  import dafir_pkg::*;
#(
  parameter int TAPS     = 8,
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic [SAMPLE_W-1:0]          inSample,
  input  logic                         coefWrEn,
  input  logic [$clog2(TAPS)-1:0]      coefWrAddr,
  input  logic signed [COEF_W-1:0]     coefWrData,
  output logic                         outValid,
  output logic signed [COEF_W+1+$clog2(TAPS/2)+SAMPLE_W-1:0] outY
);

  localparam int ADDR_W = $clog2(TAPS);
  localparam int PAIRS  = TAPS / 2;
  localparam int PSEL_W = (ADDR_W > 1) ? ADDR_W - 1 : 1;
  localparam int OW     = COEF_W + 1 + $clog2(PAIRS) + SAMPLE_W;
  localparam int LAT    = 2 + $clog2(PAIRS) + $clog2(SAMPLE_W);

  strobe_t           strb;
  logic [PSEL_W-1:0] pairSel;

  initial begin
    if (TAPS % 2 != 0 || TAPS < 2) $error("TAPS must be even and at least 2");
  end

  dafir_ctrl #(.ADDR_W(ADDR_W), .PSEL_W(PSEL_W), .LAT(LAT)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .coefWrEn   (coefWrEn),
    .coefWrAddr (coefWrAddr),
    .strb       (strb),
    .pairSel    (pairSel),
    .outValid   (outValid)
  );

  dafir_datapath #(
    .TAPS(TAPS), .L(SAMPLE_W), .W(COEF_W), .PSEL_W(PSEL_W), .OW(OW)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pairSel  (pairSel),
    .sample   (inSample),
    .coefData (coefWrData),
    .yOut     (outY)
  );

endmodule

// File: tb/dafir_top_test.sv
module dafir_top_test;

  localparam int TAPS = 8;
  localparam int SW   = 8;
  localparam int CWD  = 8;
  localparam int AW   = $clog2(TAPS);
  localparam int OW   = CWD + 1 + $clog2(TAPS/2) + SW;
  localparam int LAT  = 2 + $clog2(TAPS/2) + $clog2(SW);
  localparam int QD   = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [SW-1:0] inSample = '0;
  logic coefWrEn = 1'b0;
  logic [AW-1:0] coefWrAddr = '0;
  logic signed [CWD-1:0] coefWrData = '0;
  logic outValid;
  logic signed [OW-1:0] outY;

  dafir_top #(.TAPS(TAPS), .SAMPLE_W(SW), .COEF_W(CWD)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSample(inSample),
    .coefWrEn(coefWrEn), .coefWrAddr(coefWrAddr), .coefWrData(coefWrData),
    .outValid(outValid), .outY(outY)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;
  int hModel [TAPS];
  int xModel [TAPS];
  longint expQ [QD];
  int accQ [QD];
  string tagQ [QD];
  int wrPtr = 0;
  int rdPtr = 0;
  string phaseTag = "R1";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // one clock of stimulus; model tracks the same edge
  task automatic step(input bit v, input int s, input bit we, input int a, input int d);
    longint acc;
    @(negedge clk);
    inValid = v;
    inSample = SW'(s);
    coefWrEn = we;
    coefWrAddr = AW'(a);
    coefWrData = CWD'(d);
    if (we) hModel[a] = d;
    if (v) begin
      for (int k = TAPS - 1; k > 0; k--) xModel[k] = xModel[k-1];
      xModel[0] = s;
      acc = 0;
      for (int k = 0; k < TAPS; k++) acc += longint'(hModel[k]) * longint'(xModel[k]);
      expQ[wrPtr % QD] = acc;
      accQ[wrPtr % QD] = cyc;
      tagQ[wrPtr % QD] = phaseTag;
      wrPtr++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0);
  endtask

  task automatic loadSet(input int kind);
    for (int k = 0; k < TAPS; k++) begin
      int v;
      case (kind)
        0: v = (k % 2 == 0) ? (3 + 4 * k) : -(5 + 6 * k);
        1: v = 127;
        2: v = -128;
        3: v = (k % 2 == 0) ? 127 : -128;
        default: v = (k == TAPS - 1) ? -128 : (1 << k);
      endcase
      step(0, 0, 1, k, v);
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (rdPtr == wrPtr) begin
        check(0, "R4", "output with no accepted sample", longint'(outY), 0);
      end else begin
        check(longint'(outY) == expQ[rdPtr % QD], tagQ[rdPtr % QD], "outY",
              longint'(outY), expQ[rdPtr % QD]);
        check(cyc - accQ[rdPtr % QD] == LAT, "R3", "latency",
              cyc - accQ[rdPtr % QD], LAT);
        rdPtr++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int k = 0; k < TAPS; k++) begin hModel[k] = 0; xModel[k] = 0; end
    repeat (3) @(negedge clk);
    check(outValid == 1'b0, "R1", "outValid in reset", outValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
    end

    // R1: zero taps give zero output
    phaseTag = "R1";
    for (int i = 0; i < 12; i++) step(1, 255 - i * 9, 0, 0, 0);
    idle(LAT + 2);

    // R5: impulse reveals each tap position
    phaseTag = "R5";
    loadSet(4);
    step(1, 1, 0, 0, 0);
    for (int i = 0; i < TAPS + 2; i++) step(1, 0, 0, 0, 0);
    idle(LAT + 2);

    // R2 and R6: full sample sweep, back-to-back, over several tap sets
    for (int set = 0; set < 4; set++) begin
      phaseTag = "R2";
      loadSet(set);
      phaseTag = (set == 0) ? "R6" : "R2";
      for (int i = 0; i < 256; i++) step(1, (i * 37 + 5 + set) % 256, 0, 0, 0);
      idle(LAT + 2);
    end

    // R7: extreme operands
    phaseTag = "R7";
    loadSet(2);
    for (int i = 0; i < TAPS + 4; i++) step(1, 255, 0, 0, 0);
    loadSet(1);
    for (int i = 0; i < TAPS + 4; i++) step(1, 255, 0, 0, 0);
    idle(LAT + 2);

    // R4: bubbles between valid samples
    phaseTag = "R4";
    loadSet(0);
    for (int i = 0; i < 120; i++) step(i % 3 != 0, (i * 53 + 11) % 256, 0, 0, 0);
    idle(LAT + 2);

    // R5: tap writes interleaved with streaming samples
    phaseTag = "R5";
    for (int i = 0; i < 96; i++)
      step(i % 5 != 4, (i * 71 + 3) % 256, i % 2 == 0, (i / 2) % TAPS, ((i * 29) % 256) - 128);
    idle(LAT + 4);

    check(rdPtr == wrPtr, "R3", "outputs delivered", rdPtr, wrPtr);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule